// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

A register-mapped watchdog for a processor subsystem. A 16-bit down-counter runs from a programmable reload value, either once per clock or once per prescaler period. Software keeps it from expiring by writing two fixed 16-bit keys, in order, to a service register. When the count runs out while the timer is enabled, the block either pulses a reset request for a fixed number of cycles or raises an interrupt that stays high until the next valid service.

The control register accepts exactly one write after power-on. Any later write is dropped, so neither the enable state nor the expiry mode can be changed by runaway code. Reading the control register back shows the configuration actually in force. A sticky flag in the count word records that the watchdog requested a reset. The block is reset only by power-on, so the flag survives the system reset it caused. Software clears the flag by writing 1 to it. For debugging, a freeze option lets an external halt input stop both the counter and the prescaler.

Top module: `wdog_keyed`

## Requirements
- R1: After power-on reset the control word reads 0xFFFF0007 (reload 0xFFFF, enabled, reset mode, prescale on). The count word reads 0x0000FFFF. Offsets 0x0 and 0xC read 0. Both expiry outputs are low.
- R2: The register map is as follows. Offset 0x4 is the control word. Offset 0x8 is the count word, with the count in bits 15:0 and the reset-cause flag in bit 16. Offset 0xC takes service keys in bits 31:16. Offsets 0x0 and 0xC read as zero.
- R3: A service write carries its key in bits 31:16, with strobes 3 and 2 both set. Writing key 0x556C and then key 0xAA39 loads the counter from the reload field and restarts the prescaler. The new value is visible after the edge that takes the second key.
- R4: The first control write after power-on that has any strobe set updates only the strobed byte lanes, then locks the register. Every later control write is ignored.
- R5: The control word layout is: bits 31:16 hold the reload value, bit 3 is freeze, bit 2 is enable, bit 1 selects reset mode (1) or interrupt mode (0), and bit 0 turns the prescaler on. Bits 15:4 read 0, and a read returns the configuration in effect.
- R6: With the prescaler off, the counter drops by one on every clock. With it on, the counter drops once every 2^PRE_LOG2 clocks, counted from the service.
- R7: The counter trips on the first edge at which it is already zero and the timer is enabled and not frozen. After a service with reload N, this is the clock edge that comes one clock after the count reaches zero. In reset mode, the reset request is high for exactly RST_PULSE cycles. In interrupt mode, the interrupt stays high until the next valid service.
- R8: A trip in reset mode sets the cause flag (count word bit 16). Writing 1 to bit 16 with strobe 2 set clears the flag. Writing 0 to it leaves the flag unchanged.
- R9: When the second key is expected and any other key is written, the sequence returns to waiting for the first key. A lone 0xAA39 does nothing. Service writes without both strobes 3 and 2 are ignored and leave the sequence where it was.
- R10: While the freeze bit is set and the halt input is high, the counter and the prescaler hold. The freeze bit alone has no effect.
- R11: While the timer is disabled, the counter holds its value and never trips. A service still loads the reload value.
- R12: The counter never goes below zero, and it trips only once per service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write enable, single cycle |
| bus_strb | input | 4 | Byte-lane strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| dbg_halt | input | 1 | Debug halt; freezes the timer when the freeze bit is set |
| wdt_rst_req | output | 1 | Reset request pulse on expiry in reset mode |
| wdt_irq | output | 1 | Interrupt on expiry in interrupt mode, held until serviced |

## Verification
The assertions assume that power-on reset is held for at least two clock edges before any access. They also assume that bus inputs change only between edges, and that the address on a write is word-aligned. The bench follows both rules: it drives every access on the falling edge, applies one clock-wide write strobes, and holds reset for three edges. The bench sets a small prescaler and a short reset pulse. This lets it sweep every reload from 1 to 6 across both prescale settings and both expiry modes, and predict the count and the trip time arithmetically for each.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
// Package: shared offsets, service keys, control bit positions and types
// for the keyed-service watchdog. Assumes a 32-bit little-endian data bus.
package wdog_pkg;

    // Register byte offsets
    localparam logic [3:0] OFF_RSVD = 4'h0;
    localparam logic [3:0] OFF_CTRL = 4'h4;
    localparam logic [3:0] OFF_CNT  = 4'h8;
    localparam logic [3:0] OFF_SVC  = 4'hC;

    // Service keys, accepted in this order only
    localparam logic [15:0] KEY_FIRST  = 16'h556C;
    localparam logic [15:0] KEY_SECOND = 16'hAA39;

    // Control word bit positions
    localparam int B_PRE = 0;
    localparam int B_SEL = 1;
    localparam int B_EN  = 2;
    localparam int B_FRZ = 3;
    localparam int B_CAUSE = 16;   // cause flag inside the count word

    localparam logic [31:0] CTRL_RST  = 32'hFFFF_0007;
    localparam logic [31:0] CTRL_MASK = 32'hFFFF_000F;

    typedef struct packed {
        logic [15:0] reload;
        logic        freeze;
        logic        enable;
        logic        rst_sel;
        logic        pre_en;
    } wd_cfg_t;

    typedef enum logic {
        KS_IDLE  = 1'b0,
        KS_ARMED = 1'b1
    } key_state_t;

endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
// Register file: write-once control word with byte lanes, the sticky
// reset-cause flag, service-write decode and the read mux.
// Assumes word-aligned byte addresses and single-cycle write strobes.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [3:0]        strb,
    input  logic [31:0]       wdata,
    input  logic [15:0]       cnt,
    input  logic              trip_rst,
    output wd_cfg_t           cfg,
    output logic              svc_wr,
    output logic [15:0]       svc_key,
    output logic [31:0]       rdata
);

    logic [31:0] ctrl_q;
    logic        lock_q;
    logic        cause_q;
    logic        ctrl_wr;
    logic        cause_clr;
    logic [31:0] ctrl_eff;

    assign ctrl_wr   = we && (addr == ADDR_W'(OFF_CTRL)) && (strb != 4'b0000);
    assign cause_clr = we && (addr == ADDR_W'(OFF_CNT)) && strb[2] && wdata[B_CAUSE];
    assign svc_wr    = we && (addr == ADDR_W'(OFF_SVC)) && (strb[3:2] == 2'b11);
    assign svc_key   = wdata[31:16];
    assign ctrl_eff  = ctrl_q & CTRL_MASK;

    // Expose the effective configuration as named fields
    always_comb begin
        cfg.reload  = ctrl_eff[31:16];
        cfg.freeze  = ctrl_eff[B_FRZ];
        cfg.enable  = ctrl_eff[B_EN];
        cfg.rst_sel = ctrl_eff[B_SEL];
        cfg.pre_en  = ctrl_eff[B_PRE];
    end

    // Control word: the first write merges strobed lanes, then locks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            lock_q <= 1'b0;
        end else if (ctrl_wr && !lock_q) begin
            for (int b = 0; b < 4; b++) begin
                if (strb[b]) ctrl_q[8*b +: 8] <= wdata[8*b +: 8];
            end
            lock_q <= 1'b1;
        end
    end

    // Sticky cause flag: set by a reset-mode trip, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n)          cause_q <= 1'b0;
        else if (trip_rst)   cause_q <= 1'b1;
        else if (cause_clr)  cause_q <= 1'b0;
    end

    // Read mux over the register map
    always_comb begin
        unique case (addr)
            ADDR_W'(OFF_CTRL): rdata = ctrl_eff;
            ADDR_W'(OFF_CNT):  rdata = {15'd0, cause_q, cnt};
            default:           rdata = 32'd0;
        endcase
    end

    assert_ctrl_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_q) |-> $stable(ctrl_q));

    assert_cause_set_by_trip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_q) |-> $past(trip_rst));

    assert_cause_clear_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cause_q) |-> $past(we && strb[2] && wdata[B_CAUSE]));

endmodule

// File: rtl/wdog_keyseq.sv
`timescale 1ns/1ps
// Service key sequencer: recognises the first key followed directly by the
// second key. Any other service write returns it to waiting for the first.
// Assumes svc_wr is already qualified by address and strobes.
module wdog_keyseq
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        svc_wr,
    input  logic [15:0] svc_key,
    output logic        svc_ok
);

    key_state_t state_q;

    assign svc_ok = svc_wr && (state_q == KS_ARMED) && (svc_key == KEY_SECOND);

    // Track whether the first key was the most recent service write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
        end else if (svc_wr) begin
            if (state_q == KS_IDLE && svc_key == KEY_FIRST) state_q <= KS_ARMED;
            else                                            state_q <= KS_IDLE;
        end
    end

    assert_no_back_to_back_service_R9: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> !svc_ok);

endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
// Down-counter with optional prescaler, freeze and expiry outputs.
// Trips once when the count is zero while running; a reset-mode trip
// pulses rst_req for PULSE cycles, an interrupt-mode trip holds irq until service.
// Assumes PRE_LOG2 >= 1 and PULSE >= 1.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int PRE_LOG2 = 16,
    parameter int PULSE    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  wd_cfg_t     cfg,
    input  logic        svc_ok,
    input  logic        dbg_halt,
    output logic [15:0] cnt,
    output logic        rst_req,
    output logic        irq,
    output logic        trip_rst
);

    localparam int PW = $clog2(PULSE + 1);

    logic [PRE_LOG2-1:0] pre_q;
    logic [15:0]         cnt_q;
    logic                tripped_q;
    logic [PW-1:0]       pulse_q;
    logic                irq_q;
    logic                hold;
    logic                tick;
    logic                expire;

    assign hold     = !cfg.enable || (cfg.freeze && dbg_halt);
    assign tick     = cfg.pre_en ? (&pre_q) : 1'b1;
    assign expire   = !svc_ok && !hold && (cnt_q == 16'd0) && !tripped_q;
    assign trip_rst = expire && cfg.rst_sel;
    assign cnt      = cnt_q;
    assign rst_req  = (pulse_q != '0);
    assign irq      = irq_q;

    // Prescaler and count: reload on service, otherwise step while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q     <= '0;
            cnt_q     <= 16'hFFFF;
            tripped_q <= 1'b0;
        end else if (svc_ok) begin
            pre_q     <= '0;
            cnt_q     <= cfg.reload;
            tripped_q <= 1'b0;
        end else if (!hold) begin
            if (cfg.pre_en)                  pre_q <= pre_q + PRE_LOG2'(1);
            if (tick && cnt_q != 16'd0)      cnt_q <= cnt_q - 16'd1;
            if (expire)                      tripped_q <= 1'b1;
        end
    end

    // Reset-request pulse stretcher
    always_ff @(posedge clk) begin
        if (!rst_n)                     pulse_q <= '0;
        else if (trip_rst)              pulse_q <= PW'(PULSE);
        else if (pulse_q != '0)         pulse_q <= pulse_q - PW'(1);
    end

    // Interrupt: set on an interrupt-mode trip, cleared by a valid service
    always_ff @(posedge clk) begin
        if (!rst_n)                     irq_q <= 1'b0;
        else if (svc_ok)                irq_q <= 1'b0;
        else if (expire && !cfg.rst_sel) irq_q <= 1'b1;
    end

    assert_service_reloads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> (cnt_q == $past(cfg.reload)));

    assert_irq_only_in_irq_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(!cfg.rst_sel));

    assert_rst_only_in_rst_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(cfg.rst_sel));

    assert_hold_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !svc_ok) |=> $stable(cnt_q));

    assert_no_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == 16'd0 && !svc_ok) |=> (cnt_q == 16'd0));

endmodule

// File: rtl/wdog_keyed.sv
`timescale 1ns/1ps
// Top of the keyed-service watchdog: ties the register file, the key
// sequencer and the counter together. rst_n is the power-on reset only,
// so the cause flag survives the system reset this block requests.
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int PRE_LOG2  = 16,
    parameter int RST_PULSE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [3:0]        bus_strb,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dbg_halt,
    output logic              wdt_rst_req,
    output logic              wdt_irq
);

    wd_cfg_t     cfg;
    logic        svc_wr;
    logic [15:0] svc_key;
    logic        svc_ok;
    logic [15:0] cnt;
    logic        trip_rst;

    wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .strb     (bus_strb),
        .wdata    (bus_wdata),
        .cnt      (cnt),
        .trip_rst (trip_rst),
        .cfg      (cfg),
        .svc_wr   (svc_wr),
        .svc_key  (svc_key),
        .rdata    (bus_rdata)
    );

    wdog_keyseq u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .svc_wr  (svc_wr),
        .svc_key (svc_key),
        .svc_ok  (svc_ok)
    );

    wdog_counter #(.PRE_LOG2(PRE_LOG2), .PULSE(RST_PULSE)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .svc_ok   (svc_ok),
        .dbg_halt (dbg_halt),
        .cnt      (cnt),
        .rst_req  (wdt_rst_req),
        .irq      (wdt_irq),
        .trip_rst (trip_rst)
    );

endmodule

// File: tb/sim_wdog_keyed.sv
`timescale 1ns/1ps
// Bench: sweeps reload, prescale and mode on a small configuration and
// checks the count trajectory and trip timing arithmetically.
module sim_wdog_keyed;

    localparam int CLK_PERIOD = 10;
    localparam int PRE_LOG2   = 3;
    localparam int PULSE      = 4;
    localparam int PDIV       = 1 << PRE_LOG2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_strb = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        wdt_rst_req;
    logic        wdt_irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_keyed #(.ADDR_W(4), .PRE_LOG2(PRE_LOG2), .RST_PULSE(PULSE)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_strb(bus_strb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_halt(dbg_halt), .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic por();
        rst_n = 1'b0; bus_we = 1'b0; bus_strb = 4'h0; dbg_halt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
        bus_addr = a; bus_wdata = d; bus_strb = s; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_strb = 4'h0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic key(input logic [15:0] k);
        wr(4'hC, {k, 16'h0000}, 4'hC);
    endtask

    task automatic service();
        key(16'h556C);
        key(16'hAA39);
    endtask

    // Watchdog: a hung run is a failure and still reports
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] cv;
        int first, highs, mism;

        // R1 / R2: power-on state and map
        por();
        rd(4'h0, v); chk("R1 reserved offset", v, 32'h0);
        rd(4'h4, v); chk("R1 control default", v, 32'hFFFF_0007);
        rd(4'h8, v); chk("R1 count default", v, 32'h0000_FFFF);
        rd(4'hC, v); chk("R2 service reads zero", v, 32'h0);
        chk("R1 outputs low", {30'd0, wdt_rst_req, wdt_irq}, 32'h0);

        // Main sweep: reload x prescale x mode (R3 R6 R7 R8 R12)
        for (int r = 1; r <= 6; r++) begin
            for (int p = 0; p < 2; p++) begin
                for (int s = 0; s < 2; s++) begin
                    int d;
                    d = (p != 0) ? PDIV : 1;
                    por();
                    cv = (32'(r) << 16) | 32'h4 | (32'(s) << 1) | 32'(p);
                    wr(4'h4, cv, 4'hF);
                    rd(4'h4, v); chk("R4 R5 control readback", v, cv);
                    service();
                    rd(4'h8, v); chk("R3 reload after service", v, 32'(r));
                    first = -1; highs = 0; mism = 0;
                    for (int k = 1; k <= r*d + PULSE + 4; k++) begin
                        int e;
                        @(negedge clk);
                        e = (k <= r*d) ? (r - k/d) : 0;
                        if (bus_rdata[15:0] != 16'(e)) mism++;
                        if (((s != 0) ? wdt_rst_req : wdt_irq) && first < 0) first = k;
                        if (wdt_rst_req) highs++;
                    end
                    chk("R6 R12 count trajectory mismatches", mism, 0);
                    chk("R7 trip cycle", first, r*d + 1);
                    if (s != 0) begin
                        chk("R7 reset pulse width", highs, PULSE);
                        chk("R12 single trip, irq quiet", {31'd0, wdt_irq}, 0);
                        rd(4'h8, v); chk("R8 cause set", {31'd0, v[16]}, 1);
                        wr(4'h8, 32'h0, 4'h4);
                        rd(4'h8, v); chk("R8 write zero keeps cause", {31'd0, v[16]}, 1);
                        wr(4'h8, 32'h0001_0000, 4'h4);
                        rd(4'h8, v); chk("R8 write one clears cause", {31'd0, v[16]}, 0);
                    end else begin
                        chk("R7 irq held", {31'd0, wdt_irq}, 1);
                        chk("R7 no reset in irq mode", highs, 0);
                        rd(4'h8, v); chk("R8 cause clear in irq mode", {31'd0, v[16]}, 0);
                        service();
                        chk("R7 irq cleared by service", {31'd0, wdt_irq}, 0);
                        rd(4'h8, v); chk("R3 reload after trip", v, 32'(r));
                    end
                end
            end
        end

        // R4 R5 R11: reserved bits, lock, disabled timer
        por();
        wr(4'h4, 32'h1234_FFF2, 4'hF);
        rd(4'h4, v); chk("R5 reserved bits zero", v, 32'h1234_0002);
        wr(4'h4, 32'hFFFF_FFFF, 4'hF);
        rd(4'h4, v); chk("R4 second write ignored", v, 32'h1234_0002);
        rd(4'h8, v); chk("R11 disabled holds count", v, 32'h0000_FFFF);
        service();
        bus_addr = 4'h8;
        highs = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (wdt_rst_req || wdt_irq) highs++;
        end
        rd(4'h8, v); chk("R11 service loads, no decrement", v, 32'h0000_1234);
        chk("R11 no trip while disabled", highs, 0);

        // R4: byte-lane first write
        por();
        wr(4'h4, 32'hAB00_0005, 4'h1);
        rd(4'h4, v); chk("R4 lane merge", v, 32'hFFFF_0005);
        wr(4'h4, 32'h0, 4'h8);
        rd(4'h4, v); chk("R4 locked after lane write", v, 32'hFFFF_0005);

        // R9: key sequence errors, timer disabled so count only moves on reload
        por();
        wr(4'h4, 32'h0009_0000, 4'hF);
        key(16'hAA39);
        rd(4'h8, v); chk("R9 lone second key", v, 32'h0000_FFFF);
        key(16'h556C); key(16'h1234); key(16'hAA39);
        rd(4'h8, v); chk("R9 wrong key breaks sequence", v, 32'h0000_FFFF);
        key(16'h556C); key(16'h556C); key(16'hAA39);
        rd(4'h8, v); chk("R9 repeated first key breaks sequence", v, 32'h0000_FFFF);
        key(16'h556C);
        wr(4'hC, 32'hAA39_0000, 4'h4);
        rd(4'h8, v); chk("R9 partial strobe ignored", v, 32'h0000_FFFF);
        key(16'hAA39);
        rd(4'h8, v); chk("R9 R3 sequence survives ignored write", v, 32'h0000_0009);

        // R10: freeze with prescaler, interrupt mode
        por();
        wr(4'h4, 32'h0003_000D, 4'hF);
        service();
        bus_addr = 4'h8;
        repeat (4) @(negedge clk);
        rd(4'h8, v); chk("R10 freeze bit alone runs", v, 32'h3);
        dbg_halt = 1'b1;
        first = -1;
        for (int k = 5; k <= 45; k++) begin
            @(negedge clk);
            if (k == 14) dbg_halt = 1'b0;
            if (wdt_irq && first < 0) first = k;
        end
        chk("R10 frozen cycles delay trip", first, 3*PDIV + 1 + 10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule